// File: doc/BRIEF.md
# Compressed Branch Trace Nibble Serializer

This block turns branch destination addresses from a processor core into a narrow trace stream. There is one 4-bit data bus and one active-low sync line, and both change on the peripheral clock. When no branch is waiting, the bus shows a fixed idle pattern. When a branch is taken, the block sends one header nibble and then only the low-order part of the address that differs from the last address it sent in full. A debug host reads the header to learn how many address nibbles follow. It then rebuilds the full address by merging those nibbles into its own copy of the previous one.

A one-entry holding slot takes every incoming branch. The controller is a three-state machine. ST_IDLE waits for the slot to fill and takes the transition IDLE->HEAD when it does. ST_HEAD drives the header for one cycle and always takes HEAD->BODY. ST_BODY drives the address nibbles. After the last nibble it takes BODY->HEAD if another branch is waiting, and BODY->IDLE if not. A branch that arrives while the slot is already full replaces the waiting one and sets a sticky overflow flag.

Top module: `brt_trace_port`

## Requirements
- R1: After reset, and whenever no packet is being sent, `trc_data` is 4'b0011 and `trc_sync_n` is 1.
- R2: A packet starts with one header cycle. In that cycle `trc_sync_n` is 1 and `trc_data` is {2'b10, size code}. The first address nibble follows in the very next cycle.
- R3: The size code is chosen by comparing against the reference address, narrowest match first. It is 2'b00 when bits 31..4 are equal, 2'b01 when bits 31..8 are equal, 2'b10 when bits 31..16 are equal, and 2'b11 otherwise.
- R4: After the header come 1, 2, 4 or 8 address nibbles, for codes 00, 01, 10 and 11. They go out lowest first: bits 3..0 first, then 7..4, and so on. `trc_sync_n` is 0 in every address nibble cycle.
- R5: The reference is the full address of the last packet that was sent completely. After reset there is no valid reference, so the first packet always uses code 2'b11.
- R6: A branch that arrives during a packet is held. If it is still waiting when the last nibble of the current packet is sent, its header appears in the very next cycle, with no idle cycle in between. Its size code is computed against the packet that just finished.
- R7: `ovf_flag` is 0 after reset. A branch that arrives while one is already waiting, and is not being taken that cycle, replaces the waiting branch, which is never sent. The same event sets `ovf_flag`, which stays 1 until reset.
- R8: If nothing is waiting after the last address nibble, the bus shows the idle pattern in the next cycle.
- R9: When the block is idle, a branch sampled with `br_valid` on one rising edge shows its header from the following rising edge onward. In the cycle between those two edges the bus still shows the idle pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | Single-cycle pulse marking a taken branch |
| br_addr | input | 32 | Branch destination address, sampled while `br_valid` is 1 |
| trc_data | output | 4 | Trace nibble: the idle pattern, a header, or an address nibble |
| trc_sync_n | output | 1 | Low while an address nibble is on `trc_data` |
| ovf_flag | output | 1 | Sticky flag: a waiting branch was overwritten |

## Verification
The assertions look only at the trace port and at `br_valid`. They assume that `br_valid` is synchronous to `clk` and that `br_addr` is stable whenever `br_valid` is high. They make no assumption about how often branches arrive, because overflow is itself a checked behaviour. The stimulus changes inputs only on falling edges. It sends branches both into an idle port and in the middle of a packet, at fixed offsets. It spaces single branches far enough apart that the expected packet order follows from the arrival times alone.

// File: rtl/brt_pkg.sv
package brt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_BODY = 2'd2
    } brt_state_e;

    typedef enum logic [1:0] {
        SZ_N1 = 2'b00,
        SZ_N2 = 2'b01,
        SZ_N4 = 2'b10,
        SZ_N8 = 2'b11
    } brt_size_e;

    localparam logic [3:0] BRT_IDLE_NIB = 4'b0011;
    localparam logic [1:0] BRT_HEAD_TAG = 2'b10;

endpackage

// File: rtl/brt_size_cmp.sv
module brt_size_cmp
    import brt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NIB_W  = 4
) (
    input  logic [ADDR_W-1:0] cand_addr,
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic              ref_ok,
    output brt_size_e         size_code
);
    localparam int LVL_N = 3;

    logic [LVL_N-1:0] upper_hit;

    // Level g checks that everything above the low (NIB_W << g) bits matches.
    generate
        for (genvar g = 0; g < LVL_N; g++) begin : g_lvl
            localparam int LO = NIB_W << g;
            assign upper_hit[g] = ref_ok &&
                (cand_addr[ADDR_W-1:LO] == ref_addr[ADDR_W-1:LO]);
        end
    endgenerate

    // The narrowest match wins.
    always_comb begin
        if (upper_hit[0])      size_code = SZ_N1;
        else if (upper_hit[1]) size_code = SZ_N2;
        else if (upper_hit[2]) size_code = SZ_N4;
        else                   size_code = SZ_N8;
    end

endmodule

// File: rtl/brt_pend_slot.sv
module brt_pend_slot #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              pop,
    output logic              slot_vld,
    output logic [ADDR_W-1:0] slot_addr,
    output logic              ovf_seen
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_vld  <= 1'b0;
            slot_addr <= '0;
            ovf_seen  <= 1'b0;
        end else begin
            if (push) begin
                slot_vld  <= 1'b1;
                slot_addr <= push_addr;
            end else if (pop) begin
                slot_vld  <= 1'b0;
            end
            // An entry that is not being taken gets overwritten.
            if (push && slot_vld && !pop) begin
                ovf_seen <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/brt_trace_port.sv
module brt_trace_port
    import brt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_addr,
    output logic [NIB_W-1:0]  trc_data,
    output logic              trc_sync_n,
    output logic              ovf_flag
);
    localparam int NIB_CNT = ADDR_W / NIB_W;
    localparam int IDX_W   = $clog2(NIB_CNT);

    brt_state_e        state_q, state_d;
    logic [ADDR_W-1:0] cur_addr;
    brt_size_e         cur_code;
    logic [IDX_W-1:0]  nib_idx;
    logic [IDX_W-1:0]  last_idx;
    logic [ADDR_W-1:0] ref_addr;
    logic              ref_ok;

    logic              slot_vld;
    logic [ADDR_W-1:0] slot_addr;
    logic              finishing;
    logic              take;
    logic [ADDR_W-1:0] cmp_ref;
    logic              cmp_ok;
    brt_size_e         cmp_code;

    brt_pend_slot #(.ADDR_W(ADDR_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (br_valid),
        .push_addr (br_addr),
        .pop       (take),
        .slot_vld  (slot_vld),
        .slot_addr (slot_addr),
        .ovf_seen  (ovf_flag)
    );

    // On a back-to-back handover, compare against the packet that is finishing.
    assign cmp_ref = finishing ? cur_addr : ref_addr;
    assign cmp_ok  = finishing | ref_ok;

    brt_size_cmp #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_cmp (
        .cand_addr (slot_addr),
        .ref_addr  (cmp_ref),
        .ref_ok    (cmp_ok),
        .size_code (cmp_code)
    );

    always_comb begin
        unique case (cur_code)
            SZ_N1:   last_idx = IDX_W'(0);
            SZ_N2:   last_idx = IDX_W'(1);
            SZ_N4:   last_idx = IDX_W'(3);
            default: last_idx = IDX_W'(NIB_CNT - 1);
        endcase
    end

    assign finishing = (state_q == ST_BODY) && (nib_idx == last_idx);
    assign take      = slot_vld && ((state_q == ST_IDLE) || finishing);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take) state_d = ST_HEAD;
            ST_HEAD: state_d = ST_BODY;
            ST_BODY: if (finishing) state_d = take ? ST_HEAD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and the datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cur_addr <= '0;
            cur_code <= SZ_N8;
            nib_idx  <= '0;
            ref_addr <= '0;
            ref_ok   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take) begin
                cur_addr <= slot_addr;
                cur_code <= cmp_code;
            end
            if (state_q == ST_HEAD)      nib_idx <= '0;
            else if (state_q == ST_BODY) nib_idx <= nib_idx + IDX_W'(1);
            if (finishing) begin
                ref_addr <= cur_addr;
                ref_ok   <= 1'b1;
            end
        end
    end

    // Output decode.
    always_comb begin
        trc_data   = BRT_IDLE_NIB;
        trc_sync_n = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                trc_data   = BRT_IDLE_NIB;
                trc_sync_n = 1'b1;
            end
            ST_HEAD: begin
                trc_data   = {BRT_HEAD_TAG, cur_code};
                trc_sync_n = 1'b1;
            end
            ST_BODY: begin
                trc_data   = cur_addr[nib_idx*NIB_W +: NIB_W];
                trc_sync_n = 1'b0;
            end
            default: begin
                trc_data   = BRT_IDLE_NIB;
                trc_sync_n = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/brt_trace_chk.sv
module brt_trace_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       br_valid,
    input logic [3:0] trc_data,
    input logic       trc_sync_n,
    input logic       ovf_flag
);
    logic       is_head;
    logic [1:0] head_code;
    logic [3:0] body_cnt;
    logic       seen_head;

    assign is_head = trc_sync_n && (trc_data[3:2] == 2'b10);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_code <= 2'b11;
            body_cnt  <= '0;
            seen_head <= 1'b0;
        end else if (is_head) begin
            head_code <= trc_data[1:0];
            body_cnt  <= '0;
            seen_head <= 1'b1;
        end else if (!trc_sync_n) begin
            body_cnt <= body_cnt + 4'd1;
        end
    end

    AST_IDLE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        trc_sync_n |-> (trc_data == 4'b0011 || trc_data[3:2] == 2'b10)); // R1

    AST_HEAD_THEN_BODY: assert property (@(posedge clk) disable iff (!rst_n)
        is_head |=> !trc_sync_n); // R2

    AST_BODY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !trc_sync_n |-> ($past(!trc_sync_n) || $past(trc_data[3:2] == 2'b10))); // R4

    AST_BODY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trc_sync_n) |-> (body_cnt == (4'd1 << head_code))); // R4

    AST_FIRST_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (is_head && !seen_head) |-> (trc_data[1:0] == 2'b11)); // R5

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag); // R7

    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(br_valid)); // R7

endmodule

bind brt_trace_port brt_trace_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .br_valid   (br_valid),
    .trc_data   (trc_data),
    .trc_sync_n (trc_sync_n),
    .ovf_flag   (ovf_flag)
);

// File: tb/sim_brt_trace_port.sv
`timescale 1ns/1ps
module sim_brt_trace_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0;
    logic [31:0] br_addr = '0;
    logic [3:0]  trc_data;
    logic        trc_sync_n;
    logic        ovf_flag;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] m_ref    = '0;
    bit          m_ref_ok = 1'b0;

    always #10 clk = ~clk;

    brt_trace_port u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .br_valid   (br_valid),
        .br_addr    (br_addr),
        .trc_data   (trc_data),
        .trc_sync_n (trc_sync_n),
        .ovf_flag   (ovf_flag)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_code(input logic [31:0] a);
        logic [31:0] d;
        d = a ^ m_ref;
        if (!m_ref_ok)            return 2'b11;
        if (d[31:4] == '0)        return 2'b00;
        if (d[31:8] == '0)        return 2'b01;
        if (d[31:16] == '0)       return 2'b10;
        return 2'b11;
    endfunction

    task automatic check_idle(input string req);
        check(trc_sync_n == 1'b1 && trc_data == 4'b0011, req,
              {27'd0, trc_sync_n, trc_data}, 32'h13);
    endtask

    task automatic pulse(input logic [31:0] a);
        br_valid = 1'b1;
        br_addr  = a;
        @(negedge clk);
        br_valid = 1'b0;
    endtask

    // Called at the falling edge where the header is expected.
    task automatic recv(input logic [31:0] a, input string req);
        logic [1:0] c;
        int n;
        c = exp_code(a);
        n = 1 << c;
        check(trc_sync_n == 1'b1 && trc_data == {2'b10, c}, req,
              {27'd0, trc_sync_n, trc_data}, {27'd0, 1'b1, 2'b10, c});
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check(trc_sync_n == 1'b0 && trc_data == a[4*k +: 4], "R4",
                  {27'd0, trc_sync_n, trc_data}, {28'd0, a[4*k +: 4]});
        end
        @(negedge clk);
        m_ref    = a;
        m_ref_ok = 1'b1;
    endtask

    task automatic do_pkt(input logic [31:0] a, input string req);
        pulse(a);
        check_idle("R9");
        @(negedge clk);
        recv(a, req);
        check_idle("R8");
    endtask

    initial begin
        logic [31:0] lfsr;
        logic [31:0] a_pk, b_pk, c_pk;
        repeat (3) @(negedge clk);
        check_idle("R1");
        check(ovf_flag == 1'b0, "R7", {31'd0, ovf_flag}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");

        // R5: first packet after reset is full width
        do_pkt(32'h1234_5678, "R5");

        // R3: flip each single bit of the reference
        for (int p = 0; p < 32; p++) begin
            do_pkt(m_ref ^ (32'd1 << p), "R3");
        end
        do_pkt(m_ref, "R3");

        // R3: pseudo-random changes confined to 4, 8, 16 or 32 low bits
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 40; i++) begin
            logic [31:0] msk;
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            case (i % 4)
                0: msk = 32'h0000_000F;
                1: msk = 32'h0000_00FF;
                2: msk = 32'h0000_FFFF;
                default: msk = 32'hFFFF_FFFF;
            endcase
            do_pkt(m_ref ^ (lfsr & msk), "R3");
        end

        // R6: branch arrives mid-packet, follows with no idle gap
        a_pk = m_ref ^ 32'h8000_0000;
        b_pk = a_pk ^ 32'h0000_0010;
        pulse(a_pk);
        fork
            begin @(negedge clk); recv(a_pk, "R6"); end
            begin repeat (3) @(negedge clk); pulse(b_pk); end
        join
        recv(b_pk, "R6");
        check_idle("R8");
        check(ovf_flag == 1'b0, "R7", {31'd0, ovf_flag}, 32'd0);

        // R7: two branches mid-packet, the later one wins
        a_pk = m_ref ^ 32'h4000_0000;
        b_pk = 32'hDEAD_BEEF;
        c_pk = a_pk ^ 32'h0000_0100;
        pulse(a_pk);
        fork
            begin @(negedge clk); recv(a_pk, "R7"); end
            begin
                repeat (2) @(negedge clk);
                pulse(b_pk);
                @(negedge clk);
                pulse(c_pk);
            end
        join
        check(ovf_flag == 1'b1, "R7", {31'd0, ovf_flag}, 32'd1);
        recv(c_pk, "R7");
        for (int j = 0; j < 4; j++) begin
            check_idle("R7");
            @(negedge clk);
        end

        // R7: flag stays set across later traffic
        do_pkt(m_ref ^ 32'h0000_0003, "R3");
        check(ovf_flag == 1'b1, "R7", {31'd0, ovf_flag}, 32'd1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule